// File: doc/BRIEF.md
# Monitor Interrupt Status Aggregator

This block gathers error flags from a round-robin hardware monitor into latched status bits. A bit is set when its source reports an error at the end of a conversion cycle. It holds until software reads the status byte that contains it, and that read clears the byte. A second view of each status byte, the mirror, returns the same bits without clearing anything. Per-bit masks, an interrupt enable, an interrupt-clear control and a thermal mask combine the latched bits into one active-low interrupt pin.

Three kinds of source feed the block. General error flags arrive as a vector that is sampled on each `cycle_done` strobe. The external thermal alarm pin is sampled on the same strobe, but only while the block is not itself driving that pin low. Hardware temperature-limit errors go into a separate sticky latch that a status read cannot clear. The interrupt-clear control also drives `loop_halt`, which stops the monitoring loop while it is set.

The register port is plain control, not a stream. The block accepts a read or a write on every cycle and never applies back-pressure. Read data appears one cycle after `rd_en`, marked by `rd_valid`.

Top module: `irq_status_agg`

## Requirements
- R1: A read of status byte 0 or 1 (address 0 covers bits 7:0, address 1 covers bits 15:8) returns the byte's contents on `rd_data` one cycle after `rd_en`, with `rd_valid` high. The byte is then zero, so a repeat read before the next sample returns 0.
- R2: Mirror addresses 2 and 3 return the same bits as addresses 0 and 1, and reading them clears nothing.
- R3: Mask bytes at addresses 4 and 5 hold one mask bit for each status bit. A mask bit at 1 stops that status bit from driving `int_n`, but the status bit still sets and reads back as usual.
- R4: If a source sets a bit in the same cycle that a read clears its byte, the bit stays set after the read.
- R5: `int_n` is active low. It is low only when bit 1 of control register A (address 6) is 1 and some unmasked status bit, or the hardware-limit latch, is set.
- R6: While bit 3 of control register A is 1, `int_n` is high, `loop_halt` is high and `cycle_done` strobes update no status bit.
- R7: A hardware-limit error (`hw_lim_evt` at a sample) drives `int_n` low and survives reads of every status byte. It clears while control B bit 0 is 1, while control A bit 3 is 1, or while control A bit 1 is 0.
- R8: With bit 0 of control register B (address 7) at 1, thermal status bits 11:8 and the hardware-limit latch do not affect `int_n`, but bits 11:8 still set on samples.
- R9: Status bit 11 is the thermal alarm. It sets at a sample when `alarm_n` is low and `alarm_self_drv` is low. It sets again at the next sample if the pin is still low after a read has cleared it. It never sets while `alarm_self_drv` is high, and `err_evt[11]` is ignored.
- R10: After reset, all registers read 0, `int_n` is high and `loop_halt` is low. Writes to the status and mirror addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_done | input | 1 | End-of-conversion strobe; error inputs are sampled here |
| err_evt | input | 16 | Per-source error flags (bit 11 unused) |
| hw_lim_evt | input | 1 | Hardware temperature-limit error flag |
| alarm_n | input | 1 | Thermal alarm pin level, active low |
| alarm_self_drv | input | 1 | High while the block's own output holds the alarm pin low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |
| rd_valid | output | 1 | Marks `rd_data` valid |
| int_n | output | 1 | Interrupt output, active low |
| loop_halt | output | 1 | Stops the monitoring loop |

## Verification
The assertions assume that the source inputs and `err_evt` are known whenever `cycle_done` is high. They also assume that read and write strobes carry an in-range address. The bench draws every address from 0 to 7. It drives `cycle_done`, flags and pin levels as full-width values with no unknown bits, so every sample and decode the properties reason about is defined. The random phase mixes writes to the control and mask registers with samples and reads, so halt and mask states change while events arrive.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W         = 8;
  localparam int CA_INT_EN     = 1;
  localparam int CA_INT_CLR    = 3;
  localparam int CB_THERM_MASK = 0;

  typedef struct packed {
    logic int_en;
    logic int_clr;
    logic therm_mask;
  } ctl_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N_SRC     = 16,
  parameter int REG_W     = 8,
  parameter int ALARM_BIT = 11,
  localparam int NB       = N_SRC / REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic [N_SRC-1:0] err_evt,
  input  logic             alarm_n,
  input  logic             alarm_self_drv,
  input  logic [NB-1:0]    rd_clr_byte,
  output logic [N_SRC-1:0] status
);
  logic             alarm_hit;
  logic [N_SRC-1:0] set_vec;

  assign alarm_hit = !alarm_n && !alarm_self_drv;

  always_comb begin
    set_vec            = err_evt;
    set_vec[ALARM_BIT] = alarm_hit;
    if (!sample) set_vec = '0;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] set_b;
    assign set_b = set_vec[b*REG_W +: REG_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (rd_clr_byte[b] ? '0 : q) | set_b;
    end
    assign status[b*REG_W +: REG_W] = q;

    // R1: a clearing read with no new event empties the byte
    a_r1_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_byte[b] && set_b == '0) |=> (q == '0));
  end

  // R4: a new event is never lost, even against a clearing read
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R9: a self-driven alarm pin never raises the alarm bit
  a_r9_self_drive_blind: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_self_drv && !status[ALARM_BIT]) |=> !status[ALARM_BIT]);
endmodule

// File: rtl/irq_hw_latch.sv
module irq_hw_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic hw_evt,
  input  logic clr_cond,
  output logic hw_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hw_err <= 1'b0;
    else if (clr_cond) hw_err <= 1'b0;
    else if (sample && hw_evt) hw_err <= 1'b1;
  end

  // R7: only the clear conditions release the latch
  a_r7_hw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_err && !clr_cond) |=> hw_err);

  // R7: any clear condition empties it
  a_r7_hw_released: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cond |=> !hw_err);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_agg_pkg::*;
#(
  parameter int N_SRC   = 16,
  localparam int NB     = N_SRC / REG_W,
  localparam int A_MIR  = NB,
  localparam int A_MSK  = 2 * NB,
  localparam int A_CA   = 3 * NB,
  localparam int A_CB   = 3 * NB + 1,
  localparam int ADDR_W = $clog2(3 * NB + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [N_SRC-1:0]  status,
  output logic [N_SRC-1:0]  mask,
  output ctl_t              ctl,
  output logic [NB-1:0]     rd_clr_byte,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_valid
);
  logic [REG_W-1:0] ca_q, cb_q, rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= '0;
      cb_q <= '0;
      mask <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_CA)) ca_q <= wr_data;
      if (addr == ADDR_W'(A_CB)) cb_q <= wr_data;
      for (int b = 0; b < NB; b++)
        if (addr == ADDR_W'(A_MSK + b)) mask[b*REG_W +: REG_W] <= wr_data;
    end
  end

  assign ctl.int_en     = ca_q[CA_INT_EN];
  assign ctl.int_clr    = ca_q[CA_INT_CLR];
  assign ctl.therm_mask = cb_q[CB_THERM_MASK];

  always_comb begin
    rd_mux      = '0;
    rd_clr_byte = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr == ADDR_W'(b)) begin
        rd_mux         = status[b*REG_W +: REG_W];
        rd_clr_byte[b] = rd_en;
      end
      if (addr == ADDR_W'(A_MIR + b)) rd_mux = status[b*REG_W +: REG_W];
      if (addr == ADDR_W'(A_MSK + b)) rd_mux = mask[b*REG_W +: REG_W];
    end
    if (addr == ADDR_W'(A_CA)) rd_mux = ca_q;
    if (addr == ADDR_W'(A_CB)) rd_mux = cb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R1: every read strobe yields data on the next cycle
  a_r1_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int               N_SRC      = 16,
  parameter logic [N_SRC-1:0] THERM_BITS = 16'h0F00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] status,
  input  logic [N_SRC-1:0] mask,
  input  logic             hw_err,
  input  logic             int_en,
  input  logic             int_clr,
  input  logic             therm_mask,
  output logic             int_n
);
  logic [N_SRC-1:0] eff;
  logic             req;

  assign eff   = status & ~mask & ~(therm_mask ? THERM_BITS : '0);
  assign req   = (|eff) || (hw_err && !therm_mask);
  assign int_n = !(int_en && !int_clr && req);

  // R3: fully masked status with no limit error keeps the pin high
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (((status & ~mask) == '0) && !hw_err) |-> int_n);

  // R8: with the thermal mask, only non-thermal bits can pull the pin
  a_r8_therm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_mask && ((status & ~mask & ~THERM_BITS) == '0)) |-> int_n);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int               N_SRC      = 16,
  parameter int               ALARM_BIT  = 11,
  parameter logic [N_SRC-1:0] THERM_BITS = 16'h0F00,
  localparam int              NB         = N_SRC / REG_W,
  localparam int              ADDR_W     = $clog2(3 * NB + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_done,
  input  logic [N_SRC-1:0]  err_evt,
  input  logic              hw_lim_evt,
  input  logic              alarm_n,
  input  logic              alarm_self_drv,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              int_n,
  output logic              loop_halt
);
  logic [N_SRC-1:0] status, mask;
  logic [NB-1:0]    rd_clr_byte;
  ctl_t             ctl;
  logic             sample, hw_err, hw_clr;

  assign loop_halt = ctl.int_clr;
  assign sample    = cycle_done && !loop_halt;
  assign hw_clr    = ctl.therm_mask || ctl.int_clr || !ctl.int_en;

  irq_regfile #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .status(status), .mask(mask), .ctl(ctl),
    .rd_clr_byte(rd_clr_byte), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  irq_status_bank #(.N_SRC(N_SRC), .REG_W(REG_W), .ALARM_BIT(ALARM_BIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .sample(sample), .err_evt(err_evt),
    .alarm_n(alarm_n), .alarm_self_drv(alarm_self_drv),
    .rd_clr_byte(rd_clr_byte), .status(status)
  );

  irq_hw_latch u_hw (
    .clk(clk), .rst_n(rst_n), .sample(sample), .hw_evt(hw_lim_evt),
    .clr_cond(hw_clr), .hw_err(hw_err)
  );

  irq_combine #(.N_SRC(N_SRC), .THERM_BITS(THERM_BITS)) u_comb (
    .clk(clk), .rst_n(rst_n), .status(status), .mask(mask), .hw_err(hw_err),
    .int_en(ctl.int_en), .int_clr(ctl.int_clr), .therm_mask(ctl.therm_mask),
    .int_n(int_n)
  );

  // R6: halted loop keeps the interrupt released
  a_r6_halt_releases: assert property (@(posedge clk) disable iff (!rst_n)
    loop_halt |-> int_n);

  // R6: while halted, only reads may change status
  a_r6_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_halt && !rd_en) |=> $stable(status));

  // R2: mirror reads leave status untouched
  a_r2_mirror_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= ADDR_W'(NB) && addr < ADDR_W'(2 * NB) && !sample) |=> $stable(status));
endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
  logic        clk = 0, rst_n = 0;
  logic        cycle_done = 0, hw_lim_evt = 0, alarm_n = 1, alarm_self_drv = 0;
  logic [15:0] err_evt = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [7:0]  wr_data = '0, rd_data;
  logic        rd_valid, int_n, loop_halt;

  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;
  string cur_req = "R10";

  logic [15:0] m_stat = '0, m_mask = '0;
  logic [7:0]  m_ca = '0, m_cb = '0, m_rd = '0;
  logic        m_hw = 0;
  localparam logic [15:0] THERM = 16'h0F00;

  always #2.5 clk = ~clk;

  irq_status_agg dut (
    .clk(clk), .rst_n(rst_n), .cycle_done(cycle_done), .err_evt(err_evt),
    .hw_lim_evt(hw_lim_evt), .alarm_n(alarm_n), .alarm_self_drv(alarm_self_drv),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .int_n(int_n), .loop_halt(loop_halt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_int();
    logic [15:0] eff;
    eff = m_stat & ~m_mask & ~(m_cb[0] ? THERM : 16'h0);
    return !(m_ca[1] && !m_ca[3] && ((|eff) || (m_hw && !m_cb[0])));
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0, 3'd2: return m_stat[7:0];
      3'd1, 3'd3: return m_stat[15:8];
      3'd4:       return m_mask[7:0];
      3'd5:       return m_mask[15:8];
      3'd6:       return m_ca;
      default:    return m_cb;
    endcase
  endfunction

  task automatic tick();
    logic        samp, hclr, exp_v;
    logic [15:0] setv, clrv;
    samp  = cycle_done && !m_ca[3];
    setv  = samp ? ((err_evt & ~16'h0800) | ((!alarm_n && !alarm_self_drv) ? 16'h0800 : 16'h0)) : 16'h0;
    clrv  = 16'h0;
    if (rd_en && addr == 3'd0) clrv = 16'h00FF;
    if (rd_en && addr == 3'd1) clrv = 16'hFF00;
    exp_v = rd_en;
    if (rd_en) m_rd = exp_read(addr);
    hclr  = m_cb[0] || m_ca[3] || !m_ca[1];
    m_hw  = hclr ? 1'b0 : (m_hw || (samp && hw_lim_evt));
    m_stat = (m_stat & ~clrv) | setv;
    if (wr_en) begin
      case (addr)
        3'd4: m_mask[7:0]  = wr_data;
        3'd5: m_mask[15:8] = wr_data;
        3'd6: m_ca = wr_data;
        3'd7: m_cb = wr_data;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    chk({cur_req, " rd_valid"}, 32'(rd_valid), 32'(exp_v));
    if (exp_v) chk({cur_req, " rd_data"}, 32'(rd_data), 32'(m_rd));
    chk({cur_req, " int_n"}, 32'(int_n), 32'(exp_int()));
    chk({cur_req, " loop_halt"}, 32'(loop_halt), 32'(m_ca[3]));
  endtask

  task automatic idle_in();
    cycle_done = 0; err_evt = '0; hw_lim_evt = 0;
    wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a);
    idle_in(); rd_en = 1; addr = a; tick(); idle_in();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    idle_in(); wr_en = 1; addr = a; wr_data = d; tick(); idle_in();
  endtask

  task automatic conv(input logic [15:0] e, input logic hw);
    idle_in(); cycle_done = 1; err_evt = e; hw_lim_evt = hw; tick(); idle_in();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    #12; rst_n = 1; #1;
    // R10: reset state
    chk("R10 int_n", 32'(int_n), 32'd1);
    chk("R10 loop_halt", 32'(loop_halt), 32'd0);
    for (int a = 0; a < 8; a++) begin rd(3'(a)); chk("R10 reset read", 32'(rd_data), 32'd0); end

    cur_req = "R5";
    conv(16'h0001, 0);
    chk("R5 disabled", 32'(int_n), 32'd1);
    wr(3'd6, 8'h02);
    chk("R5 enabled", 32'(int_n), 32'd0);

    cur_req = "R1";
    rd(3'd0); chk("R1 first read", 32'(rd_data), 32'h01);
    chk("R1 int released", 32'(int_n), 32'd1);
    rd(3'd0); chk("R1 repeat read", 32'(rd_data), 32'h00);

    cur_req = "R2";
    conv(16'h0100, 0);
    rd(3'd3); chk("R2 mirror", 32'(rd_data), 32'h01);
    rd(3'd3); chk("R2 mirror again", 32'(rd_data), 32'h01);
    chk("R2 int held", 32'(int_n), 32'd0);
    rd(3'd1);

    cur_req = "R3";
    wr(3'd4, 8'h04);
    conv(16'h0004, 0);
    chk("R3 masked int", 32'(int_n), 32'd1);
    rd(3'd2); chk("R3 status still set", 32'(rd_data), 32'h04);
    wr(3'd4, 8'h00);
    chk("R3 unmasked int", 32'(int_n), 32'd0);
    rd(3'd0);

    cur_req = "R4";
    idle_in(); rd_en = 1; addr = 3'd0; cycle_done = 1; err_evt = 16'h0010; tick(); idle_in();
    chk("R4 read value", 32'(rd_data), 32'h00);
    rd(3'd2); chk("R4 event kept", 32'(rd_data), 32'h10);
    rd(3'd0);

    cur_req = "R9";
    alarm_n = 0;
    conv(16'h0000, 0);
    rd(3'd3); chk("R9 alarm set", 32'(rd_data), 32'h08);
    rd(3'd1); rd(3'd3); chk("R9 cleared before sample", 32'(rd_data), 32'h00);
    conv(16'h0000, 0);
    rd(3'd3); chk("R9 re-set", 32'(rd_data), 32'h08);
    rd(3'd1);
    alarm_self_drv = 1;
    conv(16'h0000, 0);
    rd(3'd3); chk("R9 self driven", 32'(rd_data), 32'h00);
    alarm_self_drv = 0; alarm_n = 1;
    conv(16'h0800, 0);
    rd(3'd3); chk("R9 evt bit ignored", 32'(rd_data), 32'h00);

    cur_req = "R8";
    wr(3'd7, 8'h01);
    conv(16'h0200, 0);
    chk("R8 thermal masked", 32'(int_n), 32'd1);
    rd(3'd3); chk("R8 status updates", 32'(rd_data), 32'h02);
    conv(16'h0001, 0);
    chk("R8 other source", 32'(int_n), 32'd0);
    rd(3'd0); rd(3'd1);
    wr(3'd7, 8'h00);

    cur_req = "R7";
    conv(16'h0000, 1);
    chk("R7 hw sets", 32'(int_n), 32'd0);
    rd(3'd0); rd(3'd1);
    chk("R7 survives reads", 32'(int_n), 32'd0);
    wr(3'd6, 8'h0A);
    wr(3'd6, 8'h02);
    chk("R7 cleared by clr bit", 32'(int_n), 32'd1);
    conv(16'h0000, 1);
    wr(3'd6, 8'h00); wr(3'd6, 8'h02);
    chk("R7 cleared by disable", 32'(int_n), 32'd1);

    cur_req = "R6";
    conv(16'h0001, 0);
    wr(3'd6, 8'h0A);
    chk("R6 int forced high", 32'(int_n), 32'd1);
    chk("R6 halt out", 32'(loop_halt), 32'd1);
    rd(3'd0);
    conv(16'h0002, 0);
    rd(3'd2); chk("R6 sample ignored", 32'(rd_data), 32'h00);
    wr(3'd6, 8'h02);

    cur_req = "R10";
    conv(16'h0000, 0);
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF);
    rd(3'd2); chk("R10 status write ignored", 32'(rd_data), 32'h00);
    chk("R10 int after writes", 32'(int_n), 32'd1);

    cur_req = "random";
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      idle_in();
      cycle_done = ($urandom_range(0, 2) == 0);
      err_evt    = 16'($urandom) & 16'($urandom);
      hw_lim_evt = ($urandom_range(0, 9) == 0);
      alarm_n    = ($urandom_range(0, 3) != 0);
      alarm_self_drv = ($urandom_range(0, 3) == 0);
      addr = 3'($urandom_range(0, 7));
      if (k < 5) rd_en = 1;
      else if (k < 7) begin
        wr_en = 1;
        wr_data = 8'($urandom);
        if (addr == 3'd6 && $urandom_range(0, 3) != 0) wr_data[3] = 1'b0;
      end
      tick();
    end
    idle_in();
    finish_run();
  end
endmodule